// File: doc/BRIEF.md
# TLB Entry Permission Checker

This block takes a translation entry that a separate lookup stage has already matched and decides whether the current access may use it. The entry holds two page descriptors, one for the even page and one for the odd page of an adjacent pair. The block picks one of them using the virtual address, checks the access against its attribute bits in a fixed priority, and either reports the first fault that applies or returns the physical address together with the read, write and execute rights the page grants.

The checker sits between the lookup and the exception logic. A request is presented with `in_vld` high. One clock later the registered result appears with `out_vld` high. Cycles without a request leave the result registers unchanged. In narrow (32-bit) mode the extended attribute bits are ignored. The block does not search for the entry and does not raise exceptions.

Top module: `tlb_perm_check`

## Requirements
- R1: The descriptor is chosen by virtual address bit [ps], where ps is the page shift after clamping. A value of 1 selects `entry_odd` and 0 selects `entry_even`.
- R2: Descriptor layout (PA_W bits): bit 0 valid, bit 1 dirty, bits [3:2] page privilege level, bit 4 exact-level flag, bit 5 no-read, bit 6 no-execute, bits [PA_W-1:12] physical page number, with bits [11:7] unused. A descriptor whose valid bit is 0 always gives fault code 1.
- R3: Access encoding: 0 fetch, 1 load, 2 store, 3 handled as a load. Faults are tested in this order and the first that applies is reported: 1 not valid; 2 fetch with no-execute set; 3 load with no-read set; 4 privilege violation; 5 store with dirty clear. Code 0 means the access is allowed.
- R4: Privilege levels are 2-bit values, with 0 the most privileged. When the exact-level flag is 0, a privilege fault occurs if the current level is numerically greater than the page level. When the flag is 1, a privilege fault occurs whenever the two levels differ.
- R5: When `wide_mode` is 0, the no-execute, no-read and exact-level bits are treated as 0.
- R6: Page-number bits that map to physical bits 12 up to ps-1 are cleared. The physical address is then the page number shifted left by 12, OR'd with the low ps bits of the virtual address.
- R7: On code 0, read is always granted, write is granted when dirty is set, and execute is granted when no-execute is clear. On any fault, `paddr` and all three rights are 0.
- R8: Results are registered. They appear, with `out_vld` high, in the cycle after `in_vld` was high. A cycle with `in_vld` low drops `out_vld` and leaves the other outputs unchanged. Reset clears every output.
- R9: A page shift below 12 is treated as 12, and one above 30 is treated as 30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Request present |
| entry_even | input | PA_W | Even-page descriptor |
| entry_odd | input | PA_W | Odd-page descriptor |
| pg_shift | input | 5 | Page size as log2 of bytes |
| acc_kind | input | 2 | Access type |
| cur_plv | input | 2 | Current privilege level |
| wide_mode | input | 1 | 1 = 64-bit attribute set, 0 = 32-bit |
| vaddr | input | VA_W | Virtual address |
| out_vld | output | 1 | Result valid |
| fault | output | 3 | Fault code, 0 = allowed |
| paddr | output | PA_W | Physical address |
| perm_r | output | 1 | Read right |
| perm_w | output | 1 | Write right |
| perm_x | output | 1 | Execute right |

## Verification
Directed cases set several fault conditions together (invalid with no-execute set, no-read with a privilege violation, and so on) so that a wrong priority order shows up as a wrong code. Both privilege modes are tested at equal, higher and lower levels. Narrow mode is tested with every extended bit set. Addresses use large pages whose page numbers have low bits set, which shows whether those bits are cleared. The shift is also set to out-of-range values to test clamping. Random descriptors, shifts, levels and access kinds then mix all of these cases, and an idle cycle with changed inputs shows whether the outputs hold.

// File: rtl/tlbpc_pkg.sv
package tlbpc_pkg;

    localparam int BASE_SHIFT = 12;
    localparam int MIN_PS     = 12;
    localparam int MAX_PS     = 30;

    localparam int POS_V    = 0;
    localparam int POS_D    = 1;
    localparam int POS_PLV  = 2;
    localparam int POS_RPLV = 4;
    localparam int POS_NR   = 5;
    localparam int POS_NX   = 6;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        FLT_NONE    = 3'd0,
        FLT_INVALID = 3'd1,
        FLT_XI      = 3'd2,
        FLT_RI      = 3'd3,
        FLT_PRIV    = 3'd4,
        FLT_DIRTY   = 3'd5
    } fault_e;

    typedef struct packed {
        logic       valid;
        logic       dirty;
        logic [1:0] plv;
        logic       exact;
        logic       no_rd;
        logic       no_ex;
    } attr_t;

    // Pull attribute bits out of the low byte of a descriptor; narrow mode masks the extended ones.
    function automatic attr_t decode_attr(input logic [7:0] low, input logic wide);
        attr_t a;
        a.valid = low[POS_V];
        a.dirty = low[POS_D];
        a.plv   = low[POS_PLV +: 2];
        a.exact = wide & low[POS_RPLV];
        a.no_rd = wide & low[POS_NR];
        a.no_ex = wide & low[POS_NX];
        return a;
    endfunction

    function automatic logic [4:0] clamp_ps(input logic [4:0] ps);
        if (ps < 5'(MIN_PS))      return 5'(MIN_PS);
        else if (ps > 5'(MAX_PS)) return 5'(MAX_PS);
        else                      return ps;
    endfunction

endpackage

// File: rtl/tlbpc_half_sel.sv
module tlbpc_half_sel
    import tlbpc_pkg::*;
#(
    parameter int EW   = 48,
    parameter int VA_W = 48
) (
    input  logic [EW-1:0]   even_d,
    input  logic [EW-1:0]   odd_d,
    input  logic [VA_W-1:0] va,
    input  logic [4:0]      ps,
    output logic [EW-1:0]   pick
);
    logic odd_pg;

    always_comb begin
        odd_pg = va[ps];
        pick   = odd_pg ? odd_d : even_d;
    end
endmodule

// File: rtl/tlbpc_rights.sv
module tlbpc_rights
    import tlbpc_pkg::*;
(
    input  attr_t      attr,
    input  acc_e       acc,
    input  logic [1:0] cur_plv,
    output fault_e     flt
);
    logic plv_bad;

    always_comb begin
        if (attr.exact) plv_bad = (cur_plv != attr.plv);
        else            plv_bad = (cur_plv > attr.plv);

        if (!attr.valid)                            flt = FLT_INVALID;
        else if (acc == ACC_FETCH && attr.no_ex)    flt = FLT_XI;
        else if ((acc == ACC_LOAD || acc == ACC_RSVD) && attr.no_rd)
                                                    flt = FLT_RI;
        else if (plv_bad)                           flt = FLT_PRIV;
        else if (acc == ACC_STORE && !attr.dirty)   flt = FLT_DIRTY;
        else                                        flt = FLT_NONE;
    end
endmodule

// File: rtl/tlbpc_addr_form.sv
module tlbpc_addr_form
    import tlbpc_pkg::*;
#(
    parameter int PA_W = 48,
    parameter int VA_W = 48
) (
    input  logic [PA_W-BASE_SHIFT-1:0] ppn,
    input  logic [VA_W-1:0]            va,
    input  logic [4:0]                 ps,
    output logic [PA_W-1:0]            pa
);
    logic [PA_W-1:0] lo_mask;
    logic [PA_W-1:0] va_ext;
    logic [PA_W-1:0] page_base;

    generate
        if (VA_W >= PA_W) begin : g_va_trunc
            assign va_ext = va[PA_W-1:0];
        end else begin : g_va_ext
            assign va_ext = {{(PA_W-VA_W){1'b0}}, va};
        end
    endgenerate

    always_comb begin
        for (int i = 0; i < PA_W; i++) begin
            lo_mask[i] = (i < int'(ps));
        end
        page_base = {ppn, {BASE_SHIFT{1'b0}}} & ~lo_mask;
        pa        = page_base | (va_ext & lo_mask);
    end
endmodule

// File: rtl/tlb_perm_check.sv
module tlb_perm_check
    import tlbpc_pkg::*;
#(
    parameter int PA_W = 48,
    parameter int VA_W = 48
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_vld,
    input  logic [PA_W-1:0] entry_even,
    input  logic [PA_W-1:0] entry_odd,
    input  logic [4:0]      pg_shift,
    input  logic [1:0]      acc_kind,
    input  logic [1:0]      cur_plv,
    input  logic            wide_mode,
    input  logic [VA_W-1:0] vaddr,
    output logic            out_vld,
    output logic [2:0]      fault,
    output logic [PA_W-1:0] paddr,
    output logic            perm_r,
    output logic            perm_w,
    output logic            perm_x
);
    localparam int PPN_W = PA_W - BASE_SHIFT;

    logic [4:0]      ps_c;
    logic [PA_W-1:0] desc;
    attr_t           attr;
    fault_e          flt;
    logic [PA_W-1:0] pa_c;
    acc_e            acc;

    assign ps_c = clamp_ps(pg_shift);
    assign acc  = acc_e'(acc_kind);

    tlbpc_half_sel #(.EW(PA_W), .VA_W(VA_W)) u_sel (
        .even_d (entry_even),
        .odd_d  (entry_odd),
        .va     (vaddr),
        .ps     (ps_c),
        .pick   (desc)
    );

    assign attr = decode_attr(desc[7:0], wide_mode);

    tlbpc_rights u_rights (
        .attr    (attr),
        .acc     (acc),
        .cur_plv (cur_plv),
        .flt     (flt)
    );

    tlbpc_addr_form #(.PA_W(PA_W), .VA_W(VA_W)) u_addr (
        .ppn (desc[PA_W-1:BASE_SHIFT]),
        .va  (vaddr),
        .ps  (ps_c),
        .pa  (pa_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
            fault   <= 3'd0;
            paddr   <= '0;
            perm_r  <= 1'b0;
            perm_w  <= 1'b0;
            perm_x  <= 1'b0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                fault <= flt;
                if (flt == FLT_NONE) begin
                    paddr  <= pa_c;
                    perm_r <= 1'b1;
                    perm_w <= attr.dirty;
                    perm_x <= !attr.no_ex;
                end else begin
                    paddr  <= '0;
                    perm_r <= 1'b0;
                    perm_w <= 1'b0;
                    perm_x <= 1'b0;
                end
            end
        end
    end

    logic unused_ok;
    assign unused_ok = ^{desc[BASE_SHIFT-1:8], PPN_W[0]};
endmodule

// File: rtl/tlbpc_chk.sv
module tlbpc_chk #(
    parameter int PA_W = 48,
    parameter int VA_W = 48
) (
    input logic            clk,
    input logic            rst,
    input logic            in_vld,
    input logic [PA_W-1:0] entry_even,
    input logic [PA_W-1:0] entry_odd,
    input logic [1:0]      acc_kind,
    input logic            wide_mode,
    input logic            out_vld,
    input logic [2:0]      fault,
    input logic [PA_W-1:0] paddr,
    input logic            perm_r,
    input logic            perm_w,
    input logic            perm_x
);
    p_vld_follow_r8: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> (!out_vld && $stable(fault) && $stable(paddr) && $stable(perm_w)));

    p_fault_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (fault != 3'd0) |-> (!perm_r && !perm_w && !perm_x && paddr == '0));

    p_match_read_r7: assert property (@(posedge clk) disable iff (rst)
        (out_vld && fault == 3'd0) |-> perm_r);

    p_code_range_r3: assert property (@(posedge clk) disable iff (rst)
        fault <= 3'd5);

    p_store_no_inhibit_r3: assert property (@(posedge clk) disable iff (rst)
        (in_vld && acc_kind == 2'd2) |=> (fault != 3'd2 && fault != 3'd3));

    p_narrow_mask_r5: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !wide_mode) |=> (fault != 3'd2 && fault != 3'd3));

    p_both_invalid_r2: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !entry_even[0] && !entry_odd[0]) |=> (fault == 3'd1));
endmodule

bind tlb_perm_check tlbpc_chk #(.PA_W(PA_W), .VA_W(VA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_vld     (in_vld),
    .entry_even (entry_even),
    .entry_odd  (entry_odd),
    .acc_kind   (acc_kind),
    .wide_mode  (wide_mode),
    .out_vld    (out_vld),
    .fault      (fault),
    .paddr      (paddr),
    .perm_r     (perm_r),
    .perm_w     (perm_w),
    .perm_x     (perm_x)
);

// File: tb/sim_tlb_perm_check.sv
`timescale 1ns/1ps
module sim_tlb_perm_check;
    localparam int PA_W = 48;
    localparam int VA_W = 48;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_vld = 1'b0;
    logic [PA_W-1:0] entry_even = '0;
    logic [PA_W-1:0] entry_odd = '0;
    logic [4:0]      pg_shift = 5'd12;
    logic [1:0]      acc_kind = 2'd0;
    logic [1:0]      cur_plv = 2'd0;
    logic            wide_mode = 1'b1;
    logic [VA_W-1:0] vaddr = '0;
    logic            out_vld;
    logic [2:0]      fault;
    logic [PA_W-1:0] paddr;
    logic            perm_r, perm_w, perm_x;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    tlb_perm_check #(.PA_W(PA_W), .VA_W(VA_W)) u0 (
        .clk(clk), .rst(rst), .in_vld(in_vld),
        .entry_even(entry_even), .entry_odd(entry_odd),
        .pg_shift(pg_shift), .acc_kind(acc_kind), .cur_plv(cur_plv),
        .wide_mode(wide_mode), .vaddr(vaddr),
        .out_vld(out_vld), .fault(fault), .paddr(paddr),
        .perm_r(perm_r), .perm_w(perm_w), .perm_x(perm_x)
    );

    function automatic logic [PA_W-1:0] mk(input logic [35:0] ppn, input logic nx, input logic nr,
                                           input logic rp, input logic [1:0] lv,
                                           input logic d, input logic v);
        return {ppn, 5'b0, nx, nr, rp, lv, d, v};
    endfunction

    task automatic model(output logic [2:0] f, output logic [PA_W-1:0] pa,
                         output logic r, output logic w, output logic x);
        int ps;
        logic [PA_W-1:0] e;
        logic nx, nr, rp, bad;
        logic [35:0] ppn;
        ps = int'(pg_shift);
        if (ps < 12) ps = 12;
        if (ps > 30) ps = 30;
        e  = vaddr[ps] ? entry_odd : entry_even;
        rp = wide_mode & e[4];
        nr = wide_mode & e[5];
        nx = wide_mode & e[6];
        bad = rp ? (cur_plv != e[3:2]) : (cur_plv > e[3:2]);
        if (!e[0])                                   f = 3'd1;
        else if (acc_kind == 2'd0 && nx)             f = 3'd2;
        else if ((acc_kind == 2'd1 || acc_kind == 2'd3) && nr) f = 3'd3;
        else if (bad)                                f = 3'd4;
        else if (acc_kind == 2'd2 && !e[1])          f = 3'd5;
        else                                         f = 3'd0;
        ppn = e[47:12] & ~((36'd1 << (ps - 12)) - 36'd1);
        if (f == 3'd0) begin
            pa = {ppn, 12'b0} | (vaddr & ((48'd1 << ps) - 48'd1));
            r = 1'b1; w = e[1]; x = !nx;
        end else begin
            pa = '0; r = 1'b0; w = 1'b0; x = 1'b0;
        end
    endtask

    task automatic check(input string tag, input logic [2:0] ef, input logic [PA_W-1:0] ep,
                         input logic er, input logic ew, input logic ex, input logic ev);
        n_chk++;
        if (fault !== ef || paddr !== ep || perm_r !== er || perm_w !== ew ||
            perm_x !== ex || out_vld !== ev) begin
            n_fail++;
            $display("FAIL %s: got vld=%b f=%0d pa=%h rwx=%b%b%b exp vld=%b f=%0d pa=%h rwx=%b%b%b",
                     tag, out_vld, fault, paddr, perm_r, perm_w, perm_x,
                     ev, ef, ep, er, ew, ex);
        end
    endtask

    task automatic apply(input string tag);
        logic [2:0] f; logic [PA_W-1:0] pa; logic r, w, x;
        model(f, pa, r, w, x);
        in_vld = 1'b1;
        @(negedge clk);
        in_vld = 1'b0;
        check(tag, f, pa, r, w, x, 1'b1);
    endtask

    task automatic setup(input logic [PA_W-1:0] ev, input logic [PA_W-1:0] od,
                         input logic [4:0] ps, input logic [1:0] acc,
                         input logic [1:0] lv, input logic wd, input logic [VA_W-1:0] va);
        entry_even = ev; entry_odd = od; pg_shift = ps; acc_kind = acc;
        cur_plv = lv; wide_mode = wd; vaddr = va;
    endtask

    initial begin
        #1000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [2:0] f0; logic [PA_W-1:0] p0; logic r0, w0, x0;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check("R8 reset", 3'd0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;
        @(negedge clk);

        // R1: pick odd or even by vaddr[ps]
        setup(mk(36'h111, 0,0,0,2'd0,1,1), mk(36'h222, 0,0,0,2'd0,1,1), 5'd12, 2'd1, 2'd0, 1, 48'h1abc);
        apply("R1 odd half");
        setup(mk(36'h111, 0,0,0,2'd0,1,1), mk(36'h222, 0,0,0,2'd0,1,1), 5'd12, 2'd1, 2'd0, 1, 48'h0abc);
        apply("R1 even half");
        // R2: invalid dominates
        setup(mk(36'h5, 1,1,1,2'd0,0,0), mk(36'h5, 1,1,1,2'd0,0,0), 5'd14, 2'd0, 2'd3, 1, 48'h0);
        apply("R2 invalid entry");
        // R3: priority order
        setup(mk(36'h5, 1,1,1,2'd0,0,1), '0, 5'd12, 2'd0, 2'd3, 1, 48'h0);
        apply("R3 XI before PRIV");
        setup(mk(36'h5, 1,1,1,2'd0,0,1), '0, 5'd12, 2'd1, 2'd3, 1, 48'h0);
        apply("R3 RI before PRIV");
        setup(mk(36'h5, 1,1,0,2'd0,0,1), '0, 5'd12, 2'd2, 2'd3, 1, 48'h0);
        apply("R3 PRIV before DIRTY");
        setup(mk(36'h5, 1,1,0,2'd3,0,1), '0, 5'd12, 2'd2, 2'd3, 1, 48'h0);
        apply("R3 DIRTY on store");
        setup(mk(36'h5, 0,1,0,2'd3,1,1), '0, 5'd12, 2'd3, 2'd0, 1, 48'h0);
        apply("R3 kind 3 behaves as load");
        // R4: privilege modes
        setup(mk(36'h7, 0,0,0,2'd1,1,1), '0, 5'd12, 2'd1, 2'd2, 1, 48'h0);
        apply("R4 lax higher level faults");
        setup(mk(36'h7, 0,0,0,2'd1,1,1), '0, 5'd12, 2'd1, 2'd0, 1, 48'h0);
        apply("R4 lax lower level ok");
        setup(mk(36'h7, 0,0,1,2'd1,1,1), '0, 5'd12, 2'd1, 2'd0, 1, 48'h0);
        apply("R4 exact mismatch faults");
        setup(mk(36'h7, 0,0,1,2'd1,1,1), '0, 5'd12, 2'd1, 2'd1, 1, 48'h0);
        apply("R4 exact match ok");
        // R5: narrow mode ignores extended bits
        setup(mk(36'h9, 1,1,1,2'd1,1,1), '0, 5'd12, 2'd0, 2'd0, 0, 48'h123);
        apply("R5 narrow fetch with no-exec");
        setup(mk(36'h9, 1,1,1,2'd1,0,1), '0, 5'd12, 2'd1, 2'd0, 0, 48'h123);
        apply("R5 narrow load with no-read");
        // R6: large page clears low page number bits
        setup(mk(36'hABCDE_FFF, 0,0,0,2'd0,1,1), '0, 5'd21, 2'd1, 2'd0, 1, 48'h0000_0012_3456);
        apply("R6 2MiB page number masking");
        // R7: write right follows dirty
        setup(mk(36'h42, 1,0,0,2'd0,0,1), '0, 5'd12, 2'd1, 2'd0, 1, 48'h0);
        apply("R7 rights without dirty, no-exec");
        // R9: clamping of page shift
        setup(mk(36'hFFFFF_FFFF, 0,0,0,2'd0,1,1), mk(36'h1, 0,0,0,2'd0,1,1), 5'd31, 2'd1, 2'd0, 1, 48'h7fff_ffff);
        apply("R9 shift above 30");
        setup(mk(36'h3, 0,0,0,2'd0,1,1), mk(36'h4, 0,0,0,2'd0,1,1), 5'd5, 2'd1, 2'd0, 1, 48'h1020);
        apply("R9 shift below 12");
        // R8: idle cycle holds results
        model(f0, p0, r0, w0, x0);
        setup(mk(36'h77, 1,1,1,2'd3,0,0), '0, 5'd20, 2'd2, 2'd3, 1, 48'hffff);
        @(negedge clk);
        check("R8 idle hold", f0, p0, r0, w0, x0, 1'b0);

        // Random mix: R3 R6 R7
        for (int i = 0; i < 500; i++) begin
            logic [PA_W-1:0] e0, e1;
            e0 = {$urandom, $urandom};
            e1 = {$urandom, $urandom};
            if ($urandom_range(0, 3) != 0) e0[0] = 1'b1;
            if ($urandom_range(0, 3) != 0) e1[0] = 1'b1;
            setup(e0, e1, 5'($urandom_range(10, 31)), 2'($urandom), 2'($urandom),
                  1'($urandom), {$urandom, $urandom});
            apply("R3/R6/R7 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule